// File: doc/BRIEF.md
# Locked-Rotor Protection Timer

This block guards a brushless motor drive against a stalled rotor. The speed loop raises an out-of-lock flag whenever the measured speed sits outside its lock window. This block measures how long that flag stays high without a break. If the flag stays high for a programmed number of timebase ticks, the block latches a trip output, and that output switches off every high-side driver. The trip stays latched until the motor is commanded to stop, the protection is disabled, or the block is reset.

The timebase is an internal prescaler that divides the system clock by `PRESCALE`, so the hold time is `hold_ticks` × `PRESCALE` clock cycles. The hold value is captured at the moment timing begins. A zero hold value acts as one tick.

The control is a four-state machine:
- `GS_IDLE`: stopped or disabled.
- `GS_ARMED`: running and in lock.
- `GS_COUNT`: running and timing an out-of-lock interval.
- `GS_TRIPPED`: the fault is latched.

Its transitions are named as follows:
- *halt*: any state goes to `GS_IDLE` when stop is high or enable is low.
- *arm*: `GS_IDLE` goes to `GS_ARMED` when running is allowed.
- *slip*: `GS_ARMED` goes to `GS_COUNT` when the flag is sampled high.
- *relock*: `GS_COUNT` goes to `GS_ARMED` when the flag is sampled low.
- *expire*: `GS_COUNT` goes to `GS_TRIPPED` when the final tick arrives while the flag is still high.

Top module: `rotor_guard`

## Requirements
- R1: After reset, `trip` and `counting` are both 0.
- R2: While `stop` is 1, `trip` and `counting` are 0 from the next clock on, whatever `unlocked` does.
- R3: The first clock edge after stop is released and enable is high only arms the block. `counting` rises one edge after `unlocked` is sampled high in the armed state, and `trip` and `counting` are never 1 together.
- R4: With `unlocked` held high, `trip` rises exactly `max(hold,1)`×`PRESCALE` edges after `counting` rises, and `counting` falls on that same edge.
- R5: A single low sample of `unlocked` before expiry drops `counting` on the next edge and makes the next interval start again from zero.
- R6: Once set, `trip` stays 1 whatever `unlocked` does, as long as stop is 0 and enable is 1.
- R7: Asserting `stop` clears a latched `trip` on the next edge.
- R8: While `enable` is 0, `trip` never asserts and `counting` stays 0.
- R9: Dropping `enable` while `trip` is latched clears it on the next edge.
- R10: `hold_ticks` is captured when counting starts, and changes during an interval do not move the trip edge.
- R11: A `hold_ticks` value of 0 behaves as 1.
- R12: If `unlocked` is sampled low on the edge where the interval would expire, no trip occurs and `counting` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unlocked | input | 1 | Out-of-lock flag from the speed discriminator, 1 = out of lock |
| stop | input | 1 | Motor stop command, 1 = stop |
| enable | input | 1 | Protection enable, 0 = bypassed |
| hold_ticks | input | HOLD_W | Hold time in prescaled ticks |
| trip | output | 1 | Latched fault; 1 forces all high-side drivers off |
| counting | output | 1 | 1 while an out-of-lock interval is being timed |

## Verification
The bench targets four corner cases:
- **Exact trip edge.** It checks the edge on which the trip rises. A design with an off-by-one error in the prescaler or tick count would trip one tick early or late.
- **Breaks in the flag.** It drops the flag for a single cycle mid-interval and on the expiry edge itself. A design that only pauses its count, instead of restarting it, would trip too soon. A design that lets expiry win over relock would trip on a flag that was not continuous.
- **Hold value handling.** It changes the hold value mid-interval and also uses a zero hold value. This exposes a design that samples the hold value live, or that treats zero as "never".
- **Clearing and holding the latch.** It clears the latch both through stop and through disable, and holds the flag low after a trip. A design that self-clears the fault, or ignores one of the two clear paths, would fail these checks.

// File: rtl/rg_pkg.sv
package rg_pkg;

    typedef enum logic [1:0] {
        GS_IDLE    = 2'd0,
        GS_ARMED   = 2'd1,
        GS_COUNT   = 2'd2,
        GS_TRIPPED = 2'd3
    } guard_state_t;

endpackage

// File: rtl/rg_prescaler.sv
module rg_prescaler #(
    parameter int PRESCALE = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    generate
        if (PRESCALE <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_divide
            localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
            logic [PW-1:0] div_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    div_q <= '0;
                end else if (!run) begin
                    div_q <= '0;
                end else if (div_q == LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            assign tick = run && (div_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/rg_hold_counter.sv
module rg_hold_counter #(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [HOLD_W-1:0] hold_in,
    output logic              expire
);
    localparam int EW = HOLD_W + 1;

    logic [HOLD_W-1:0] hold_q;
    logic [HOLD_W-1:0] ticks_q;
    logic [EW-1:0]     limit;
    logic [EW-1:0]     next_count;

    // Hold value is sampled on every idle cycle, frozen while timing.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else if (!run) begin
            hold_q <= hold_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ticks_q <= '0;
        end else if (!run) begin
            ticks_q <= '0;
        end else if (tick) begin
            ticks_q <= ticks_q + 1'b1;
        end
    end

    always_comb begin
        limit      = (hold_q == '0) ? EW'(1) : {1'b0, hold_q};
        next_count = {1'b0, ticks_q} + EW'(1);
        expire     = run && tick && (next_count >= limit);
    end

endmodule

// File: rtl/rg_fsm.sv
module rg_fsm
    import rg_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         unlocked,
    input  logic         stop,
    input  logic         enable,
    input  logic         expire,
    output guard_state_t state,
    output logic         trip,
    output logic         counting,
    output logic         run
);
    guard_state_t state_q;
    guard_state_t state_d;
    logic         halt;

    assign halt = stop || !enable;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= GS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (halt) begin
            state_d = GS_IDLE;                       // halt
        end else begin
            unique case (state_q)
                GS_IDLE:    state_d = GS_ARMED;      // arm
                GS_ARMED:   if (unlocked) state_d = GS_COUNT;   // slip
                GS_COUNT: begin
                    if (!unlocked)   state_d = GS_ARMED;        // relock
                    else if (expire) state_d = GS_TRIPPED;      // expire
                end
                GS_TRIPPED: state_d = GS_TRIPPED;
                default:    state_d = GS_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        trip     = 1'b0;
        counting = 1'b0;
        unique case (state_q)
            GS_IDLE:    ;
            GS_ARMED:   ;
            GS_COUNT:   counting = 1'b1;
            GS_TRIPPED: trip     = 1'b1;
            default:    ;
        endcase
        run = counting;
    end

    assign state = state_q;

endmodule

// File: rtl/rotor_guard.sv
module rotor_guard
    import rg_pkg::*;
#(
    parameter int HOLD_W   = 16,
    parameter int PRESCALE = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unlocked,
    input  logic              stop,
    input  logic              enable,
    input  logic [HOLD_W-1:0] hold_ticks,
    output logic              trip,
    output logic              counting
);
    guard_state_t state;
    logic         run;
    logic         tick;
    logic         expire;

    rg_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    rg_hold_counter #(.HOLD_W(HOLD_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .tick    (tick),
        .hold_in (hold_ticks),
        .expire  (expire)
    );

    rg_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .unlocked (unlocked),
        .stop     (stop),
        .enable   (enable),
        .expire   (expire),
        .state    (state),
        .trip     (trip),
        .counting (counting),
        .run      (run)
    );

endmodule

// File: rtl/rg_checker.sv
module rg_checker (
    input logic clk,
    input logic rst_n,
    input logic unlocked,
    input logic stop,
    input logic enable,
    input logic trip,
    input logic counting
);
    p_stop_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!trip && !counting));

    p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(trip && counting));

    p_trip_from_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip) |-> ($past(counting) && $past(unlocked)));

    p_break_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && !unlocked && !stop && enable) |=> (!counting && !trip));

    p_trip_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && !stop && enable) |=> trip);

    p_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!trip && !counting));

endmodule

bind rotor_guard rg_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .unlocked (unlocked),
    .stop     (stop),
    .enable   (enable),
    .trip     (trip),
    .counting (counting)
);

// File: tb/sim_rotor_guard.sv
module sim_rotor_guard;
    localparam int HW = 8;
    localparam int P  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          unlocked = 1'b0;
    logic          stop = 1'b1;
    logic          enable = 1'b1;
    logic [HW-1:0] hold_ticks = '0;
    logic          trip;
    logic          counting;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    bit model_on = 1'b0;

    always #10 clk = ~clk;

    rotor_guard #(.HOLD_W(HW), .PRESCALE(P)) u0 (
        .clk(clk), .rst_n(rst_n), .unlocked(unlocked), .stop(stop),
        .enable(enable), .hold_ticks(hold_ticks), .trip(trip), .counting(counting)
    );

    function automatic int window(input int h);
        return ((h == 0) ? 1 : h) * P;
    endfunction

    // Behavioural reference: counts consecutive high samples in clocks.
    bit m_armed, m_cnt, m_trip;
    int m_n, m_lim;
    always @(posedge clk) begin
        if (!rst_n || stop || !enable) begin
            m_armed <= 0; m_cnt <= 0; m_trip <= 0; m_n <= 0;
        end else if (!m_armed) begin
            m_armed <= 1;
        end else if (m_trip) begin
        end else if (!m_cnt) begin
            if (unlocked) begin
                m_cnt <= 1; m_n <= 0; m_lim <= window(int'(hold_ticks));
            end
        end else if (!unlocked) begin
            m_cnt <= 0;
        end else if (m_n + 1 == m_lim) begin
            m_trip <= 1; m_cnt <= 0;
        end else begin
            m_n <= m_n + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n && model_on) begin
            checks++;
            if (trip !== m_trip) begin
                errors++;
                $display("FAIL R4 model trip: actual=%0b expected=%0b @%0t", trip, m_trip, $time);
            end
            checks++;
            if (counting !== m_cnt) begin
                errors++;
                $display("FAIL R3 model counting: actual=%0b expected=%0b @%0t", counting, m_cnt, $time);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect2(input logic t, input logic c, input string tag);
        checks++;
        if (trip !== t || counting !== c) begin
            errors++;
            $display("FAIL %s: actual trip=%0b counting=%0b expected trip=%0b counting=%0b",
                     tag, trip, counting, t, c);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        step(3);
        expect2(0, 0, "R1 reset");
        rst_n = 1'b1;
        model_on = 1'b1;

        // R2: stop held with flag high
        unlocked = 1; hold_ticks = 3;
        step(20);
        expect2(0, 0, "R2 stop holds");

        // R3/R4: exact trip edge, hold 3
        stop = 0;
        step(1);
        expect2(0, 0, "R3 arm only");
        step(window(3));
        expect2(0, 1, "R4 just before expiry");
        step(1);
        expect2(1, 0, "R4 trip edge");
        unlocked = 0;
        step(5);
        expect2(1, 0, "R6 latched");
        stop = 1;
        step(1);
        expect2(0, 0, "R7 stop clears");

        // R5: single low sample restarts
        stop = 0; unlocked = 1; hold_ticks = 2;
        step(1);
        step(5);
        unlocked = 0;
        step(1);
        expect2(0, 0, "R5 relock drop");
        unlocked = 1;
        step(window(2));
        expect2(0, 1, "R5 full window restarted");
        step(1);
        expect2(1, 0, "R5 trip after restart");

        // R9 / R8
        enable = 0;
        step(1);
        expect2(0, 0, "R9 disable clears");
        step(40);
        expect2(0, 0, "R8 disabled never trips");

        // R10: hold change mid interval
        enable = 1; hold_ticks = 1;
        step(2);
        hold_ticks = 3;
        step(window(1) - 1);
        expect2(0, 1, "R10 before trip");
        step(1);
        expect2(1, 0, "R10 captured hold");
        stop = 1; step(1); stop = 0;

        // R11: zero hold
        hold_ticks = 0;
        step(2);
        step(P - 1);
        expect2(0, 1, "R11 before trip");
        step(1);
        expect2(1, 0, "R11 zero acts as one");
        stop = 1; step(1); stop = 0;

        // R12: break on expiry edge
        hold_ticks = 1;
        step(2);
        step(P - 1);
        unlocked = 0;
        step(1);
        expect2(0, 0, "R12 relock wins");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(99) < 2)  stop = ~stop;
            if ($urandom_range(199) < 2) enable = ~enable;
            if ($urandom_range(99) < 6)  unlocked = ~unlocked;
            if ($urandom_range(99) < 3)  hold_ticks = HW'($urandom_range(4));
            step(1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule